// File: doc/BRIEF.md
# Burst Beat Address and Byte-Lane Strobe Generator

This block turns one burst request into a sequence of beats. A request gives a start byte address, a transfer size, a burst kind (incrementing or wrapping) and a beat count. For each beat the block presents the beat address and a byte-lane enable mask that matches the data bus width, which is fixed by a parameter. The first beat may begin part way into a transfer, and its lanes below the start byte are then disabled. Every later beat sits on a size boundary and enables its whole transfer window. When a transfer is narrower than the bus, its window is placed on the lanes that the beat address selects.

A one-cycle `start` pulse loads a request, and the first beat appears on the outputs in the next cycle. Each cycle with `advance` high moves on to the next beat. Advancing on the final beat empties the block. A mode input lets the requester present the first beat address already rounded down to the transfer size. In that mode only the strobes show where the data starts.

Top module: `burst_strobe_gen`

## Requirements
- R1: While reset is held and after it is released with no request, `beat_valid`, `beat_last` and every bit of `beat_strb` are 0.
- R2: The cycle after a `start` pulse, `beat_valid` is 1 and `beat_addr` equals `start_addr` when `aligned_mode` is 0. A `start` pulse also abandons any burst in progress.
- R3: On the first beat, bit i of `beat_strb` drives byte lane i, which carries the byte at an address congruent to i modulo the bus width in bytes. Lanes from the start byte up to the end of its transfer window are 1. Lanes below the start byte, and all lanes outside the window, are 0.
- R4: The address of each later beat is the previous beat address rounded down to the transfer size, plus the transfer size in bytes. Every lane of the window is enabled on such a beat.
- R5: `size_code` is log2 of the transfer bytes and must not exceed log2 of the bus bytes. The window's lowest lane is the beat address modulo the bus bytes, rounded down to the transfer size. As the address rises, the window moves across the bus.
- R6: `burst_kind` 1 selects a wrapping burst and 0 an incrementing burst. A wrapping burst stays inside a region of (transfer bytes × beat count) bytes, aligned to its own size. When the next address would reach the region's top, it returns to the region's base. Wrapping bursts need a size-aligned start and a beat count of 2, 4, 8 or 16.
- R7: When `aligned_mode` is 1, the first `beat_addr` is `start_addr` rounded down to the transfer size, while `beat_strb` is the same as R3 gives for the unrounded start.
- R8: `beat_last` is 1 only on the final beat (`len_m1` + 1 beats in all). An `advance` on that beat drops `beat_valid`, and the strobes go to 0.
- R9: While `advance` is low, the beat address and strobes do not change. `advance` has no effect when no burst is active.
- R10: While a beat is valid, at least one lane and no more than the transfer bytes are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that loads a request |
| start_addr | input | ADDR_W | Start byte address, may be unaligned |
| size_code | input | 3 | log2 of transfer bytes |
| burst_kind | input | 1 | 0 incrementing, 1 wrapping |
| len_m1 | input | LEN_W | Beat count minus one |
| aligned_mode | input | 1 | 1: first beat address rounded down to the size |
| advance | input | 1 | Step to the next beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_strb | output | BUS_BYTES | Byte-lane enables of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The bench builds two copies of the block side by side: one with an 8-byte bus and one with a 4-byte bus, both with 32-bit addresses and 8-bit length. Both copies receive the same requests. This lets one word-sized burst show the narrow-window shift across the wide bus and the full-width case on the narrow bus. The listed unaligned start offsets, a wrapping burst that crosses its region top, byte transfers, aligned mode, hold and idle-advance behaviour are each compared against a byte-by-byte model in the bench.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic {
    BK_INCR = 1'b0,
    BK_WRAP = 1'b1
  } burst_kind_e;

  typedef logic [2:0] size_code_t;

endpackage

// File: rtl/bsg_beat_counter.sv
module bsg_beat_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             advance,
  output logic             valid,
  output logic             first,
  output logic             last,
  output logic             step
);

  logic             valid_q;
  logic             first_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      left_q  <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      first_q <= 1'b1;
      left_q  <= len_m1;
    end else if (valid_q && advance) begin
      first_q <= 1'b0;
      if (left_q == '0) begin
        valid_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign valid = valid_q;
  assign first = valid_q && first_q;
  assign last  = valid_q && (left_q == '0);
  assign step  = valid_q && advance && (left_q != '0) && !start;

  // R2: a start pulse always yields a valid beat next cycle
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  // R8: advancing on the last beat empties the block
  p_last_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && advance && !start) |=> !valid);

endmodule

// File: rtl/bsg_addr_stepper.sv
module bsg_addr_stepper #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  bsg_pkg::size_code_t size_code,
  input  logic                burst_kind,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                aligned_mode,
  input  logic                valid,
  input  logic                first,
  input  logic                step,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic [ADDR_W-1:0]   lane_addr,
  output bsg_pkg::size_code_t size_out
);

  function automatic logic [ADDR_W-1:0] size_mask(input bsg_pkg::size_code_t s);
    return (ADDR_W'(1) << s) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] round_down(input logic [ADDR_W-1:0] a,
                                                   input bsg_pkg::size_code_t s);
    return a & ~size_mask(s);
  endfunction

  function automatic logic [ADDR_W-1:0] region_mask(input logic [LEN_W-1:0] lm1,
                                                    input bsg_pkg::size_code_t s);
    return ((ADDR_W'(lm1) + ADDR_W'(1)) << s) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input bsg_pkg::size_code_t s,
                                                  input logic wrap,
                                                  input logic [ADDR_W-1:0] rmask);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] inc;
    base = round_down(a, s);
    inc  = base + (ADDR_W'(1) << s);
    if (wrap) return (base & ~rmask) | (inc & rmask);
    return inc;
  endfunction

  logic [ADDR_W-1:0]   cur_q;
  logic [ADDR_W-1:0]   rmask_q;
  bsg_pkg::size_code_t size_q;
  logic                wrap_q;
  logic                amode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      rmask_q <= '0;
      size_q  <= '0;
      wrap_q  <= 1'b0;
      amode_q <= 1'b0;
    end else if (start) begin
      cur_q   <= start_addr;
      rmask_q <= region_mask(len_m1, size_code);
      size_q  <= size_code;
      wrap_q  <= (burst_kind == bsg_pkg::BK_WRAP);
      amode_q <= aligned_mode;
    end else if (step) begin
      cur_q <= next_addr(cur_q, size_q, wrap_q, rmask_q);
    end
  end

  assign lane_addr = cur_q;
  assign beat_addr = (first && amode_q) ? round_down(cur_q, size_q) : cur_q;
  assign size_out  = size_q;

  // R4: beats after the first sit on a size boundary
  p_later_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !first) |-> ((beat_addr & size_mask(size_q)) == '0));

  // R7: aligned mode presents a rounded first address
  p_amode_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && amode_q) |-> ((beat_addr & size_mask(size_q)) == '0));

  // R6: a wrapping step never leaves its region
  p_wrap_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap_q) |=> ((cur_q & ~rmask_q) == ($past(cur_q) & ~rmask_q)));

endmodule

// File: rtl/bsg_strobe_former.sv
module bsg_strobe_former #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [ADDR_W-1:0]   lane_addr,
  input  bsg_pkg::size_code_t size_code,
  output logic [BUS_BYTES-1:0] strb
);

  localparam int OFF_W = $clog2(BUS_BYTES);

  logic [OFF_W:0] off_x;
  logic [OFF_W:0] bytes_x;
  logic [OFF_W:0] base_x;
  logic [OFF_W:0] end_x;

  always_comb begin
    off_x   = {1'b0, lane_addr[OFF_W-1:0]};
    bytes_x = (OFF_W+1)'(1) << size_code;
    base_x  = off_x & ~(bytes_x - (OFF_W+1)'(1));
    end_x   = base_x + bytes_x;
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    localparam logic [OFF_W:0] LANE = (OFF_W+1)'(i);
    assign strb[i] = valid && (LANE >= off_x) && (LANE < end_x);
  end

  // R10: a valid beat enables between one lane and a full transfer
  p_lane_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (($countones(strb) >= 1) && ($countones(strb) <= int'(bytes_x))));

endmodule

// File: rtl/burst_strobe_gen.sv
module burst_strobe_gen #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  parameter int LEN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [2:0]           size_code,
  input  logic                 burst_kind,
  input  logic [LEN_W-1:0]     len_m1,
  input  logic                 aligned_mode,
  input  logic                 advance,
  output logic                 beat_valid,
  output logic [ADDR_W-1:0]    beat_addr,
  output logic [BUS_BYTES-1:0] beat_strb,
  output logic                 beat_last
);

  logic                valid_w;
  logic                first_w;
  logic                last_w;
  logic                step_w;
  logic [ADDR_W-1:0]   lane_addr_w;
  bsg_pkg::size_code_t size_w;

  bsg_beat_counter #(.LEN_W(LEN_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len_m1  (len_m1),
    .advance (advance),
    .valid   (valid_w),
    .first   (first_w),
    .last    (last_w),
    .step    (step_w)
  );

  bsg_addr_stepper #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_stepper (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_addr   (start_addr),
    .size_code    (size_code),
    .burst_kind   (burst_kind),
    .len_m1       (len_m1),
    .aligned_mode (aligned_mode),
    .valid        (valid_w),
    .first        (first_w),
    .step         (step_w),
    .beat_addr    (beat_addr),
    .lane_addr    (lane_addr_w),
    .size_out     (size_w)
  );

  bsg_strobe_former #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid_w),
    .lane_addr (lane_addr_w),
    .size_code (size_w),
    .strb      (beat_strb)
  );

  assign beat_valid = valid_w;
  assign beat_last  = last_w;

  // R8: no lane is enabled without a valid beat
  p_idle_strb_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (beat_strb == '0));

  // R9: outputs hold while no step and no new request
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !advance && !start) |=> ($stable(beat_addr) && $stable(beat_strb)));

endmodule

// File: tb/burst_strobe_gen_bench.sv
`timescale 1ns/1ps
module burst_strobe_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [2:0]  size_code = '0;
  logic        burst_kind = 1'b0;
  logic [7:0]  len_m1 = '0;
  logic        aligned_mode = 1'b0;
  logic        advance = 1'b0;

  logic        v8, l8, v4, l4;
  logic [31:0] a8, a4;
  logic [7:0]  s8;
  logic [3:0]  s4;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  burst_strobe_gen #(.ADDR_W(32), .BUS_BYTES(8), .LEN_W(8)) u_burst_strobe_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .size_code(size_code), .burst_kind(burst_kind), .len_m1(len_m1),
    .aligned_mode(aligned_mode), .advance(advance),
    .beat_valid(v8), .beat_addr(a8), .beat_strb(s8), .beat_last(l8));

  burst_strobe_gen #(.ADDR_W(32), .BUS_BYTES(4), .LEN_W(8)) u_burst_strobe_gen_w4 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .size_code(size_code), .burst_kind(burst_kind), .len_m1(len_m1),
    .aligned_mode(aligned_mode), .advance(advance),
    .beat_valid(v4), .beat_addr(a4), .beat_strb(s4), .beat_last(l4));

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Byte-by-byte lane model: a lane is on when its byte lies between the
  // start byte and the end of the size-aligned transfer holding it.
  function automatic int model_strb(input int addr, input int nbytes, input int bus);
    int m = 0;
    for (int b = 0; b < bus; b++) begin
      int abyte = (addr / bus) * bus + b;
      int tbase = (addr / nbytes) * nbytes;
      if (abyte >= addr && abyte < tbase + nbytes) m |= (1 << b);
    end
    return m;
  endfunction

  task automatic run_burst(input string req, input int addr, input int sc,
                           input bit wrap, input int len, input bit amode);
    int nbytes = 1 << sc;
    int region = nbytes * len;
    int lower  = (addr / region) * region;
    int cur    = addr;
    @(negedge clk);
    start_addr = addr; size_code = 3'(sc); burst_kind = wrap;
    len_m1 = 8'(len - 1); aligned_mode = amode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      int shown = (k == 0 && amode) ? (cur / nbytes) * nbytes : cur;
      chk({req, " valid w8"}, v8, 1);
      chk({req, " valid w4"}, v4, 1);
      chk({req, " addr w8"}, a8, shown);
      chk({req, " addr w4"}, a4, shown);
      chk({req, " strb w8"}, s8, model_strb(cur, nbytes, 8));
      chk({req, " strb w4"}, s4, model_strb(cur, nbytes, 4));
      chk({req, " R8 last w8"}, l8, (k == len - 1));
      chk({req, " R8 last w4"}, l4, (k == len - 1));
      begin
        int nxt = (cur / nbytes) * nbytes + nbytes;
        if (wrap && nxt >= lower + region) nxt = lower;
        cur = nxt;
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
    chk({req, " R8 drop w8"}, v8, 0);
    chk({req, " R8 strb zero w8"}, s8, 0);
    chk({req, " R8 drop w4"}, v4, 0);
  endtask

  task automatic t_reset;
    chk("R1 valid during reset", v8, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid", v8, 0);
    chk("R1 last", l8, 0);
    chk("R1 strb w8", s8, 0);
    chk("R1 strb w4", s4, 0);
  endtask

  task automatic t_hold_and_idle;
    @(negedge clk);
    start_addr = 32'h0000_1002; size_code = 3'd2; burst_kind = 1'b0;
    len_m1 = 8'd2; aligned_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold addr", a8, 32'h1002);
    chk("R9 hold strb", s8, 8'h0C);
    chk("R2 restart valid", v8, 1);
    // R2: a new request abandons the current one
    start_addr = 32'h0000_0010; len_m1 = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 restart addr", a8, 32'h10);
    chk("R8 single beat last", l8, 1);
    advance = 1'b1;
    @(negedge clk);
    chk("R8 single beat drop", v8, 0);
    @(negedge clk);
    @(negedge clk);
    advance = 1'b0;
    chk("R9 idle advance valid", v8, 0);
    chk("R9 idle advance strb", s8, 0);
    chk("R9 idle advance addr", a8, 32'h10);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    run_burst("R2 R4 aligned 0x00x4",  32'h00, 2, 1'b0, 4, 1'b0);
    run_burst("R3 R4 start 0x01x4",    32'h01, 2, 1'b0, 4, 1'b0);
    run_burst("R3 R5 start 0x01x5",    32'h01, 2, 1'b0, 5, 1'b0);
    run_burst("R3 R5 start 0x07x5",    32'h07, 2, 1'b0, 5, 1'b0);
    run_burst("R6 wrap 0x04x4",        32'h04, 2, 1'b1, 4, 1'b0);
    run_burst("R6 wrap 0x38x8",        32'h38, 2, 1'b1, 8, 1'b0);
    run_burst("R5 R10 byte 0x05x3",    32'h05, 0, 1'b0, 3, 1'b0);
    run_burst("R5 half 0x13x3",        32'h13, 1, 1'b0, 3, 1'b0);
    run_burst("R7 amode 0x07x2",       32'h07, 2, 1'b0, 2, 1'b1);
    run_burst("R7 amode 0x1002x3",     32'h1002, 2, 1'b0, 3, 1'b1);
    t_hold_and_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule